// File: doc/BRIEF.md
# ADC Trigger Request Arbiter

This block sits between a trigger generator and a single analog-to-digital converter. Each trigger carries a channel number. The block runs one conversion at a time. A conversion can open with an optional wait for an external multiplexer to settle. After that comes a sampling phase and then a converting phase, each lasting a fixed number of clock cycles. When a conversion ends, the block reports it back to the trigger source with a one-cycle completion pulse that carries the channel number.

While a conversion is running, the block keeps at most one extra trigger, and only for the channel already being converted. That held trigger is launched after the current conversion ends, so two triggers that arrive close together are both serviced. Any other trigger that finds no room is dropped, and a one-cycle drop pulse flags it.

A power-down request never cuts a conversion short, and it never skips a held trigger. It takes effect only when the converter is idle and nothing is pending. This guarantees that the trigger source always receives its completion notice.

A three-bit status output shows the converter state with a fixed code:
- 000: idle and powered
- 001: powered down
- 010: multiplexer wait
- 100: sampling
- 110: converting

Top module: `adc_trig_arbiter`

## Requirements
- R1: After reset, status_o is 000 and start_o, done_o and drop_o are low.
- R2: When the block is idle with nothing held and power-down low, a trigger raises start_o in the same cycle. With a zero delay, status_o then reads 100 for SMP_CYC cycles and then 110 for CNV_CYC cycles. done_o is high, with done_ch_o equal to the trigger's channel, in the last 110 cycle, and status_o returns to 000 on the following cycle.
- R3: When mux_dly_i is nonzero at start, status_o reads 010 for exactly that many cycles before 100. A zero delay never shows 010.
- R4: A trigger for the channel currently converting is held when the hold slot is empty. It is launched (start_o) on the idle cycle that follows the completion, which yields a second completion.
- R5: A trigger is dropped, with drop_o high in its cycle and no conversion added, in any of these cases: it names another channel while a conversion runs; the hold slot is already full; or power-down is in effect.
- R6: With power-down requested while idle and nothing held, status_o reads 001 from the next cycle until the cycle after the request falls. No conversion starts while powered down.
- R7: A power-down request raised during a conversion is deferred. The running conversion and any held trigger complete (done_o) before status_o reads 001, and status never passes from 110 straight to 001.
- R8: When a trigger and a power-down request meet in an idle cycle with nothing held, power-down wins and the trigger is dropped.
- R9: status_o never shows 011, 101 or 111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| trig_valid_i | input | 1 | Trigger request, one per cycle |
| trig_ch_i | input | CH_W | Channel of the trigger |
| pdn_req_i | input | 1 | Power-down request (level) |
| mux_dly_i | input | DLY_W | Multiplexer settle cycles, 0 skips the wait |
| start_o | output | 1 | Pulse when a conversion is launched |
| status_o | output | 3 | Converter state code |
| done_o | output | 1 | Completion pulse to the trigger source |
| done_ch_o | output | CH_W | Channel of the completed conversion |
| drop_o | output | 1 | Pulse when a trigger is discarded |

## Verification
Two functions can land in the same cycle:
- **Power-down against trigger acceptance.** In an idle cycle, a trigger and a power-down request can arrive together. The bench drives both in one cycle with nothing held and expects a drop and no start. It also raises power-down while a conversion and a held trigger are outstanding, and expects both completions before the 001 code appears.
- **Completion against launching the held trigger.** The completion of one conversion and the launch of the held trigger fall on adjacent cycles. A fresh trigger for the same channel arriving in that launch cycle must take the hold slot again.

A behavioural model checks every cycle under directed and random stimulus.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;
  // state encoding doubles as the status code
  typedef enum logic [2:0] {
    ST_IDLE = 3'b000,
    ST_PDN  = 3'b001,
    ST_WAIT = 3'b010,
    ST_SAMP = 3'b100,
    ST_CONV = 3'b110
  } conv_st_e;
endpackage

// File: rtl/adc_trig_accept.sv
module adc_trig_accept #(
  parameter int CH_W = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            trig_valid_i,
  input  logic [CH_W-1:0] trig_ch_i,
  input  logic            pdn_req_i,
  input  logic            idle_i,
  input  logic            active_i,
  input  logic [CH_W-1:0] cur_ch_i,
  output logic            start_o,
  output logic [CH_W-1:0] start_ch_o,
  output logic            drop_o,
  output logic            pend_o
);
  logic pend_q, from_pend, new_start, busy, hold;

  always_comb begin
    from_pend  = idle_i && pend_q;
    new_start  = idle_i && !pend_q && !pdn_req_i && trig_valid_i;
    busy       = active_i || from_pend;
    // one slot, same channel only; freed in the cycle it is issued
    hold       = trig_valid_i && busy && (trig_ch_i == cur_ch_i) && (!pend_q || from_pend);
    drop_o     = trig_valid_i && !new_start && !hold;
    start_o    = from_pend || new_start;
    start_ch_o = from_pend ? cur_ch_i : trig_ch_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= (pend_q && !from_pend) || hold;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
  import adc_trig_pkg::*;
#(
  parameter int CH_W    = 3,
  parameter int DLY_W   = 4,
  parameter int SMP_CYC = 6,
  parameter int CNV_CYC = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CH_W-1:0]  start_ch_i,
  input  logic [DLY_W-1:0] mux_dly_i,
  input  logic             pdn_req_i,
  output conv_st_e         state_o,
  output logic [CH_W-1:0]  cur_ch_o,
  output logic             done_o
);
  localparam int DLY_MAX = (1 << DLY_W) - 1;
  localparam int PH_MAX  = (SMP_CYC > CNV_CYC) ? SMP_CYC : CNV_CYC;
  localparam int CNT_MAX = (PH_MAX > DLY_MAX) ? PH_MAX : DLY_MAX;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  conv_st_e         st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CH_W-1:0]  ch_q, ch_d;
  logic             last;

  assign last = (cnt_q == '0);

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    ch_d  = ch_q;
    unique case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          ch_d = start_ch_i;
          if (mux_dly_i != '0) begin
            st_d  = ST_WAIT;
            cnt_d = CNT_W'(mux_dly_i) - 1'b1;
          end else begin
            st_d  = ST_SAMP;
            cnt_d = CNT_W'(SMP_CYC - 1);
          end
        end else if (pdn_req_i) begin
          st_d = ST_PDN;
        end
      end
      ST_PDN: if (!pdn_req_i) st_d = ST_IDLE;
      ST_WAIT: begin
        if (last) begin
          st_d  = ST_SAMP;
          cnt_d = CNT_W'(SMP_CYC - 1);
        end else cnt_d = cnt_q - 1'b1;
      end
      ST_SAMP: begin
        if (last) begin
          st_d  = ST_CONV;
          cnt_d = CNT_W'(CNV_CYC - 1);
        end else cnt_d = cnt_q - 1'b1;
      end
      ST_CONV: begin
        if (last) st_d = ST_IDLE;
        else      cnt_d = cnt_q - 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      ch_q  <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      ch_q  <= ch_d;
    end
  end

  assign state_o  = st_q;
  assign cur_ch_o = ch_q;
  assign done_o   = (st_q == ST_CONV) && last;
endmodule

// File: rtl/adc_trig_arbiter.sv
module adc_trig_arbiter
  import adc_trig_pkg::*;
#(
  parameter int NUM_CH  = 8,
  parameter int DLY_W   = 4,
  parameter int SMP_CYC = 6,
  parameter int CNV_CYC = 10,
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             trig_valid_i,
  input  logic [CH_W-1:0]  trig_ch_i,
  input  logic             pdn_req_i,
  input  logic [DLY_W-1:0] mux_dly_i,
  output logic             start_o,
  output logic [2:0]       status_o,
  output logic             done_o,
  output logic [CH_W-1:0]  done_ch_o,
  output logic             drop_o
);
  conv_st_e        state;
  logic [CH_W-1:0] cur_ch, start_ch;
  logic            start, pend_w, idle, active;

  assign idle   = (state == ST_IDLE);
  assign active = (state == ST_WAIT) || (state == ST_SAMP) || (state == ST_CONV);

  adc_trig_accept #(.CH_W(CH_W)) u_acc (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .trig_valid_i (trig_valid_i),
    .trig_ch_i    (trig_ch_i),
    .pdn_req_i    (pdn_req_i),
    .idle_i       (idle),
    .active_i     (active),
    .cur_ch_i     (cur_ch),
    .start_o      (start),
    .start_ch_o   (start_ch),
    .drop_o       (drop_o),
    .pend_o       (pend_w)
  );

  adc_conv_seq #(
    .CH_W(CH_W), .DLY_W(DLY_W), .SMP_CYC(SMP_CYC), .CNV_CYC(CNV_CYC)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .start_ch_i (start_ch),
    .mux_dly_i  (mux_dly_i),
    .pdn_req_i  (pdn_req_i),
    .state_o    (state),
    .cur_ch_o   (cur_ch),
    .done_o     (done_o)
  );

  assign start_o   = start;
  assign status_o  = state;
  assign done_ch_o = cur_ch;
endmodule

// File: rtl/adc_trig_arbiter_chk.sv
module adc_trig_arbiter_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [2:0] status_i,
  input logic       start_i,
  input logic       done_i,
  input logic       pend_i
);
  // R2
  start_go_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (status_i == 3'b010 || status_i == 3'b100));
  // R3
  wait_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_i == 3'b010) |=> (status_i == 3'b010 || status_i == 3'b100));
  // R7
  conv_no_pdn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_i == 3'b110) |=> (status_i == 3'b110 || status_i == 3'b000));
  // R6
  pdn_no_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_i == 3'b001) |-> !start_i);
  // R4
  pend_issue_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && pend_i) |=> start_i);
endmodule

bind adc_trig_arbiter adc_trig_arbiter_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .status_i (status_o),
  .start_i  (start_o),
  .done_i   (done_o),
  .pend_i   (pend_w)
);

// File: tb/sim_adc_trig_arbiter.sv
module sim_adc_trig_arbiter;
  localparam int NCH = 8;
  localparam int CHW = 3;
  localparam int DW  = 4;
  localparam int SMP = 6;
  localparam int CNV = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trig_v = 1'b0;
  logic [CHW-1:0] trig_ch = '0;
  logic pdn = 1'b0;
  logic [DW-1:0] dly = '0;
  logic start_w, done_w, drop_w;
  logic [2:0] status_w;
  logic [CHW-1:0] done_ch_w;

  int total = 0, bad = 0;
  int n_done = 0, n_drop = 0, n_wait = 0;
  string req = "R1";

  always #2 clk = ~clk;

  adc_trig_arbiter #(.NUM_CH(NCH), .DLY_W(DW), .SMP_CYC(SMP), .CNV_CYC(CNV)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .trig_valid_i(trig_v), .trig_ch_i(trig_ch),
    .pdn_req_i(pdn), .mux_dly_i(dly), .start_o(start_w), .status_o(status_w),
    .done_o(done_w), .done_ch_o(done_ch_w), .drop_o(drop_w)
  );

  // reference model: phase 0 idle, 1 off, 2 wait, 3 sample, 4 convert
  int m_ph = 0, m_left = 0, m_ch = 0;
  bit m_pend = 0;
  bit fp, ns, hold, e_start, e_drop, e_done;
  logic [2:0] e_status;

  always_comb begin
    case (m_ph)
      1: e_status = 3'b001;
      2: e_status = 3'b010;
      3: e_status = 3'b100;
      4: e_status = 3'b110;
      default: e_status = 3'b000;
    endcase
    e_done  = (m_ph == 4) && (m_left == 1);
    fp      = (m_ph == 0) && m_pend;
    ns      = (m_ph == 0) && !m_pend && !pdn && trig_v;
    hold    = trig_v && ((m_ph >= 2) || fp) && (int'(trig_ch) == m_ch) && (!m_pend || fp);
    e_start = fp || ns;
    e_drop  = trig_v && !ns && !hold;
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph <= 0; m_left <= 0; m_ch <= 0; m_pend <= 0;
    end else begin
      m_pend <= (m_pend && !fp) || hold;
      case (m_ph)
        0: if (e_start) begin
             m_ch <= fp ? m_ch : int'(trig_ch);
             if (dly != 0) begin m_ph <= 2; m_left <= int'(dly); end
             else begin m_ph <= 3; m_left <= SMP; end
           end else if (pdn) m_ph <= 1;
        1: if (!pdn) m_ph <= 0;
        2: if (m_left == 1) begin m_ph <= 3; m_left <= SMP; end else m_left <= m_left - 1;
        3: if (m_left == 1) begin m_ph <= 4; m_left <= CNV; end else m_left <= m_left - 1;
        default: if (m_left == 1) m_ph <= 0; else m_left <= m_left - 1;
      endcase
    end
  end

  task automatic chk(input bit ok, input string r, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", r, what, act, exp);
    end
  endtask

  task automatic compare();
    chk(status_w == e_status, req, "status", int'(status_w), int'(e_status));
    chk(start_w == e_start, req, "start", int'(start_w), int'(e_start));
    chk(drop_w == e_drop, req, "drop", int'(drop_w), int'(e_drop));
    chk(done_w == e_done, req, "done", int'(done_w), int'(e_done));
    if (e_done) chk(int'(done_ch_w) == m_ch, req, "done_ch", int'(done_ch_w), m_ch);
    // R9 reserved codes never appear
    chk(status_w != 3'b011 && status_w != 3'b101 && status_w != 3'b111, "R9", "status_code",
        int'(status_w), 0);
    if (done_w) n_done++;
    if (drop_w) n_drop++;
    if (status_w == 3'b010) n_wait++;
  endtask

  task automatic tick(input bit tv, input int ch, input bit pd);
    @(negedge clk);
    trig_v  = tv;
    trig_ch = CHW'(ch);
    pdn     = pd;
    #1 compare();
  endtask

  task automatic idle(input int n, input bit pd);
    for (int i = 0; i < n; i++) tick(0, 0, pd);
  endtask

  task automatic clr();
    n_done = 0; n_drop = 0; n_wait = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    req = "R1";
    #1;
    chk(status_w == 3'b000, "R1", "reset_status", int'(status_w), 0);
    chk(!start_w && !done_w && !drop_w, "R1", "reset_pulses",
        int'({start_w, done_w, drop_w}), 0);

    // R2 plain conversion, no multiplexer delay
    req = "R2"; dly = 0; clr();
    tick(1, 3, 0);
    idle(20, 0);
    chk(n_done == 1, "R2", "done_count", n_done, 1);
    chk(n_wait == 0, "R3", "zero_dly_wait", n_wait, 0);

    // R3 nonzero multiplexer delay
    req = "R3"; dly = 3; clr();
    tick(1, 5, 0);
    idle(25, 0);
    chk(n_wait == 3, "R3", "wait_cycles", n_wait, 3);
    chk(n_done == 1, "R3", "done_count", n_done, 1);

    // R4 same channel held while converting
    req = "R4"; dly = 0; clr();
    tick(1, 2, 0);
    idle(3, 0);
    tick(1, 2, 0);
    idle(40, 0);
    chk(n_done == 2, "R4", "done_count", n_done, 2);
    chk(n_drop == 0, "R4", "drop_count", n_drop, 0);

    // R5 full slot and foreign channel dropped
    req = "R5"; clr();
    tick(1, 4, 0);
    tick(1, 4, 0);
    tick(1, 4, 0);
    tick(1, 6, 0);
    idle(40, 0);
    chk(n_done == 2, "R5", "done_count", n_done, 2);
    chk(n_drop == 2, "R5", "drop_count", n_drop, 2);

    // R6 power-down from idle, triggers discarded
    req = "R6"; clr();
    idle(3, 1);
    chk(status_w == 3'b001, "R6", "pdn_status", int'(status_w), 1);
    tick(1, 1, 1);
    idle(2, 0);
    chk(status_w == 3'b000, "R6", "wake_status", int'(status_w), 0);
    chk(n_drop == 1 && n_done == 0, "R6", "drop_done", n_drop * 10 + n_done, 10);

    // R7 deferred power-down with held trigger
    req = "R7"; clr();
    tick(1, 7, 0);
    tick(1, 7, 0);
    idle(40, 1);
    chk(n_done == 2, "R7", "done_before_pdn", n_done, 2);
    chk(status_w == 3'b001, "R7", "pdn_after", int'(status_w), 1);
    idle(2, 0);

    // R8 power-down and trigger collide in idle
    req = "R8"; clr();
    tick(1, 0, 1);
    idle(20, 1);
    idle(2, 0);
    chk(n_drop == 1 && n_done == 0, "R8", "collision", n_drop * 10 + n_done, 10);

    // R9 random mix against the model
    req = "R9";
    for (int i = 0; i < 3000; i++) begin
      if ((i % 16) == 0) dly = DW'($urandom_range(0, 3));
      tick(($urandom_range(0, 3) == 0), int'($urandom_range(0, 3)), ($urandom_range(0, 30) == 0));
    end
    idle(40, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule